// File: doc/BRIEF.md
# Dual-Rail Carry-Completion Adder

This block adds two unsigned operands and a carry-in, and reports on its own when the answer is ready instead of after a fixed delay. Each carry position, from the carry-in through the carry-out, is held as a pair of rails: one rail means "carry is one", the other means "carry is zero", and both low means "not yet known". Bits where both operand bits are equal settle their carry at once. Bits where the operand bits differ pass along whatever the carry below them turns out to be. So resolution ripples upward one position per clock, and a completion flag rises as soon as every position has settled.

The ripple is modelled one step per clock so that the block is synchronous and synthesizable. Latency therefore depends on the data and is set by the longest run of consecutive differing bit pairs. A user raises `start` with the operands present and keeps it high until `done` is seen. The user then reads `sum` and `cout`, and drops `start` to return the block to idle before the next operation.

Top module: `cc_adder_top`

## Requirements
- R1: While `start` is low, every carry position has both rails low, so `done`, `sum` and `cout` all read 0 from the first clock edge at which `start` is sampled low.
- R2: Once a carry position has one rail high, that rail stays high and the other stays low for as long as `start` remains high.
- R3: At the clock edge that captures an operation, a bit with both operand bits 1 drives the carry-one rail of the position above it, and a bit with both operand bits 0 drives the carry-zero rail, with no wait on lower carries. When no bit pair differs, `done` is high after that single edge.
- R4: A bit whose operand bits differ copies the rails of the carry below it, one position per clock. `done` therefore rises exactly 1 + L clock edges after capture, where L is the length of the longest run of consecutive differing bit positions (0 ≤ L ≤ WIDTH).
- R5: `done` is high only when every carry position, including the carry-out above bit WIDTH-1, has exactly one rail high. A run of differing bits that reaches the top bit delays `done` by its full length.
- R6: The carry-in is converted to dual-rail form at capture and resolves carry position 0 immediately: value 1 sets the carry-one rail and value 0 sets the carry-zero rail.
- R7: While `done` is high, `{cout, sum}` equals `a + b + cin` of the captured operands, where sum bit i is a[i] XOR b[i] XOR carry-one rail i. While `done` is low, `sum` and `cout` read 0.
- R8: `a`, `b` and `cin` are captured on the first rising edge at which `start` is high after being low. Changes to them while `start` stays high have no effect on `sum`, `cout` or the timing of `done`.
- R9: `done` falls at the first clock edge at which `start` is sampled low. A new operation needs `start` low for at least one edge and starts fresh on the next high edge.
- R10: The active-high synchronous `rst` clears all carry rails and the captured state, so `done`, `sum` and `cout` read 0 after the edge, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operation request; a low-to-high move captures operands, low returns to idle |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | WIDTH | Sum, valid while done is high, zero otherwise |
| cout | output | 1 | Carry-out, valid while done is high, zero otherwise |
| done | output | 1 | All carry positions resolved |

## Verification
The bench targets operand pairs whose differing-bit runs sit at the bottom, in the middle and at the very top of the word. A design that ignored the carry-out position, or that allowed more than one step of ripple per clock, would raise `done` early, and a top-run case catches it because `cout` or the upper sum bits would then be wrong. A full-width run with each carry-in value exercises both the worst-case latency and the dual-rail carry-in. A block that resolved position 0 from the wrong rail would either never finish or produce an off-by-one sum. Operand changes while `start` is held, a `start` drop before completion, and a reset in mid-flight check that nothing leaks into the next operation: a design that re-sampled its inputs would show a changed sum, and one that kept stale rails would finish too soon.

// File: rtl/cc_adder_pkg.sv
package cc_adder_pkg;

    // One carry position as two rails: hi = carry is one, lo = carry is zero.
    typedef struct packed {
        logic hi;
        logic lo;
    } carry_rail_t;

    // How a bit pair treats the carry that enters it.
    typedef enum logic [1:0] {
        PAIR_KILL = 2'd0,
        PAIR_PASS = 2'd1,
        PAIR_MAKE = 2'd2
    } pair_kind_e;

    localparam carry_rail_t RAIL_EMPTY = '{hi: 1'b0, lo: 1'b0};

    function automatic pair_kind_e pair_kind(input logic x, input logic y);
        pair_kind_e k;
        if (x && y)
            k = PAIR_MAKE;
        else if (!x && !y)
            k = PAIR_KILL;
        else
            k = PAIR_PASS;
        return k;
    endfunction

    function automatic logic rail_known(input carry_rail_t r);
        return r.hi | r.lo;
    endfunction

    function automatic carry_rail_t rail_of_value(input logic v);
        carry_rail_t r;
        r.hi = v;
        r.lo = ~v;
        return r;
    endfunction

endpackage

// File: rtl/cc_operand_hold.sv
module cc_operand_hold
    import cc_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             cin_in,
    output logic [WIDTH-1:0] a_held,
    output logic [WIDTH-1:0] b_held,
    output carry_rail_t      rail_base,
    output logic             busy,
    output logic             launch
);

    logic busy_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    carry_rail_t base_q;

    assign launch = start && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            base_q <= RAIL_EMPTY;
        end else if (!start) begin
            busy_q <= 1'b0;
            base_q <= RAIL_EMPTY;
        end else if (launch) begin
            busy_q <= 1'b1;
            a_q    <= a_in;
            b_q    <= b_in;
            base_q <= rail_of_value(cin_in);
        end
    end

    assign a_held    = a_q;
    assign b_held    = b_q;
    assign rail_base = base_q;
    assign busy      = busy_q;

    // R8: captured operands do not move while an operation is running
    a_r8_operands_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start) |=> ($stable(a_q) && $stable(b_q) && $stable(base_q)));

    // R6: carry position 0 is settled right after capture
    a_r6_base_settled: assert property (@(posedge clk) disable iff (rst)
        launch |=> (rail_known(base_q) && (base_q.hi == $past(cin_in))));

endmodule

// File: rtl/cc_rail_cell.sv
module cc_rail_cell
    import cc_adder_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        launch,
    input  logic        busy,
    input  logic        x_new,
    input  logic        y_new,
    input  logic        x_held,
    input  logic        y_held,
    input  carry_rail_t rail_below,
    output carry_rail_t rail_above
);

    pair_kind_e kind_new;
    pair_kind_e kind_held;
    carry_rail_t rail_q;
    carry_rail_t rail_d;

    assign kind_new  = pair_kind(x_new, y_new);
    assign kind_held = pair_kind(x_held, y_held);

    always_comb begin
        rail_d = rail_q;
        if (!start) begin
            rail_d = RAIL_EMPTY;
        end else if (launch) begin
            case (kind_new)
                PAIR_MAKE: rail_d = rail_of_value(1'b1);
                PAIR_KILL: rail_d = rail_of_value(1'b0);
                default:   rail_d = RAIL_EMPTY;
            endcase
        end else if (kind_held == PAIR_PASS) begin
            rail_d = rail_below;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rail_q <= RAIL_EMPTY;
        else
            rail_q <= rail_d;
    end

    assign rail_above = rail_q;

    // R2: a settled position holds its value while start stays high
    a_r2_settled_holds: assert property (@(posedge clk) disable iff (rst)
        (rail_known(rail_q) && start) |=> (rail_q == $past(rail_q)));

    // R3: a make pair shows carry-one as soon as the operation is live
    a_r3_make_immediate: assert property (@(posedge clk) disable iff (rst)
        (busy && kind_held == PAIR_MAKE) |-> (rail_q.hi && !rail_q.lo));

    // R3: a kill pair shows carry-zero as soon as the operation is live
    a_r3_kill_immediate: assert property (@(posedge clk) disable iff (rst)
        (busy && kind_held == PAIR_KILL) |-> (rail_q.lo && !rail_q.hi));

    // R4: a pass pair settles only after the position below has settled
    a_r4_pass_waits: assert property (@(posedge clk) disable iff (rst)
        ($rose(rail_known(rail_q)) && kind_held == PAIR_PASS) |->
            $past(rail_known(rail_below)));

endmodule

// File: rtl/cc_done_detect.sv
module cc_done_detect
    import cc_adder_pkg::*;
#(
    parameter int NPOS = 17
) (
    input  carry_rail_t [NPOS-1:0] rails,
    output logic                   all_known
);

    logic [NPOS-1:0] known_vec;

    for (genvar p = 0; p < NPOS; p++) begin : g_known
        assign known_vec[p] = rail_known(rails[p]);
    end

    assign all_known = &known_vec;

endmodule

// File: rtl/cc_sum_form.sv
module cc_sum_form
    import cc_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]     a_held,
    input  logic [WIDTH-1:0]     b_held,
    input  carry_rail_t [WIDTH:0] rails,
    input  logic                 valid,
    output logic [WIDTH-1:0]     sum,
    output logic                 cout
);

    logic [WIDTH-1:0] raw_sum;

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign raw_sum[i] = a_held[i] ^ b_held[i] ^ rails[i].hi;
    end

    assign sum  = valid ? raw_sum : '0;
    assign cout = valid ? rails[WIDTH].hi : 1'b0;

endmodule

// File: rtl/cc_adder_top.sv
module cc_adder_top
    import cc_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             done
);

    localparam int NPOS = WIDTH + 1;

    logic [WIDTH-1:0] a_held;
    logic [WIDTH-1:0] b_held;
    logic             busy;
    logic             launch;
    carry_rail_t [NPOS-1:0] rails;
    carry_rail_t      rail_base;
    logic             cin_held_q;

    cc_operand_hold #(.WIDTH(WIDTH)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .a_in      (a),
        .b_in      (b),
        .cin_in    (cin),
        .a_held    (a_held),
        .b_held    (b_held),
        .rail_base (rail_base),
        .busy      (busy),
        .launch    (launch)
    );

    assign rails[0] = rail_base;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        cc_rail_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .start      (start),
            .launch     (launch),
            .busy       (busy),
            .x_new      (a[i]),
            .y_new      (b[i]),
            .x_held     (a_held[i]),
            .y_held     (b_held[i]),
            .rail_below (rails[i]),
            .rail_above (rails[i+1])
        );
    end

    cc_done_detect #(.NPOS(NPOS)) u_done (
        .rails     (rails),
        .all_known (done)
    );

    cc_sum_form #(.WIDTH(WIDTH)) u_sum (
        .a_held (a_held),
        .b_held (b_held),
        .rails  (rails),
        .valid  (done),
        .sum    (sum),
        .cout   (cout)
    );

    // Carry-in kept only for the arithmetic check below.
    always_ff @(posedge clk) begin
        if (rst)
            cin_held_q <= 1'b0;
        else if (launch)
            cin_held_q <= cin;
    end

    // R1: start sampled low leaves the block idle
    a_r1_idle_after_low: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && sum == '0 && !cout));

    // R5: completion implies the carry-out position is settled one-hot
    a_r5_cout_settled: assert property (@(posedge clk) disable iff (rst)
        done |-> (rails[WIDTH].hi != rails[WIDTH].lo));

    // R7: the reported result matches arithmetic addition of the held operands
    a_r7_sum_matches: assert property (@(posedge clk) disable iff (rst)
        done |-> ({cout, sum} == ({1'b0, a_held} + {1'b0, b_held} + NPOS'(cin_held_q))));

    // R9: completion only while an operation is running
    a_r9_done_needs_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R10: the edge after reset shows an idle block
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && !busy));

endmodule

// File: tb/cc_adder_top_tb_top.sv
module cc_adder_top_tb_top;

    localparam int W       = 16;
    localparam int CLK_PER = 10;
    localparam int WDOG    = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    logic         done;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    string cur_req = "R10";

    // reference model state
    bit           m_busy = 0;
    int           m_edges = 0;
    int           m_need = 0;
    logic [W:0]   m_total = '0;

    cc_adder_top #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout), .done(done)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic int longest_pass_run(input logic [W-1:0] x, input logic [W-1:0] y);
        int best = 0;
        int run = 0;
        for (int i = 0; i < W; i++) begin
            if (x[i] != y[i]) begin
                run++;
                if (run > best) best = run;
            end else begin
                run = 0;
            end
        end
        return best;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic tick();
        bit   e_done;
        logic [W-1:0] e_sum;
        logic e_cout;
        @(posedge clk);
        if (rst) begin
            m_busy = 0; m_edges = 0;
        end else if (!start) begin
            m_busy = 0; m_edges = 0;
        end else if (!m_busy) begin
            m_busy  = 1;
            m_edges = 1;
            m_need  = 1 + longest_pass_run(a, b);
            m_total = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
        end else begin
            m_edges++;
        end
        @(negedge clk);
        cycles++;
        e_done = m_busy && (m_edges >= m_need);
        e_sum  = e_done ? m_total[W-1:0] : '0;
        e_cout = e_done ? m_total[W] : 1'b0;
        vectors++;
        if (done !== e_done) begin
            miscompares++;
            $display("FAIL %s done: got %0b expected %0b (cycle %0d)", cur_req, done, e_done, cycles);
        end
        if (sum !== e_sum || cout !== e_cout) begin
            miscompares++;
            $display("FAIL %s result: got %0b_%h expected %0b_%h (cycle %0d)",
                     cur_req, cout, sum, e_cout, e_sum, cycles);
        end
        if (cycles > WDOG) begin
            miscompares++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    endtask

    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                          input string req);
        int lat;
        cur_req = req;
        lat = 1 + longest_pass_run(x, y);
        a = x; b = y; cin = c; start = 1'b1;
        for (int k = 0; k < lat + 2; k++) tick();
        start = 1'b0;
        tick();
        tick();
    endtask

    initial begin
        // R10: reset state
        cur_req = "R10";
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1: operands wiggle while start is low; nothing shows
        cur_req = "R1";
        for (int k = 0; k < 4; k++) begin
            a = W'(16'h1234 * (k + 1)); b = ~a; cin = k[0];
            tick();
        end

        // R3: all make pairs, all kill pairs
        run_op('1, '1, 1'b0, "R3");
        run_op('0, '0, 1'b1, "R3");
        run_op(16'hF0F0, 16'hF0F0, 1'b1, "R3");

        // R6: full-width pass run, both carry-in values (worst latency)
        run_op(16'hFFFF, 16'h0000, 1'b1, "R6");
        run_op(16'h0000, 16'hFFFF, 1'b0, "R6");

        // R4: runs in the middle and at the bottom
        run_op(16'h00F0, 16'h0F00, 1'b0, "R4");
        run_op(16'h0001, 16'h0000, 1'b1, "R4");
        run_op(16'h5555, 16'h2AAA, 1'b1, "R4");

        // R5: run reaching the top bit delays completion through carry-out
        run_op(16'h8000, 16'h0000, 1'b0, "R5");
        run_op(16'hFF00, 16'h00FF, 1'b0, "R5");
        run_op(16'hC000, 16'h7000, 1'b1, "R5");

        // R8: operands change while start stays high
        cur_req = "R8";
        a = 16'h00FF; b = 16'h0001; cin = 1'b0; start = 1'b1;
        tick();
        a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1;
        for (int k = 0; k < 12; k++) tick();
        start = 1'b0;
        tick();

        // R9: start dropped before completion, then an immediate restart
        cur_req = "R9";
        a = 16'hFFFF; b = 16'h0000; cin = 1'b1; start = 1'b1;
        tick(); tick(); tick();
        start = 1'b0;
        tick();
        a = 16'h0F0F; b = 16'h0101; cin = 1'b0; start = 1'b1;
        for (int k = 0; k < 10; k++) tick();
        start = 1'b0;
        tick();

        // R10: reset in the middle of an operation
        cur_req = "R10";
        a = 16'h7FFF; b = 16'h0000; cin = 1'b1; start = 1'b1;
        tick(); tick(); tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        // start still high after reset: a fresh capture follows
        for (int k = 0; k < 18; k++) tick();
        start = 1'b0;
        tick();

        // R7: pseudo-random operand mix checked against addition
        begin
            logic [31:0] s = 32'h1ACE_B00C;
            for (int n = 0; n < 60; n++) begin
                s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                run_op(s[15:0], s[31:16], s[7], "R7");
            end
        end

        // R2 is guarded at each carry position; a long run keeps it busy here too
        run_op(16'h3FFC, 16'h4003, 1'b1, "R2");

        finish_run();
    end

endmodule